// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block sits at the input of an I2C target. It takes the raw SCL and SDA lines, passes each through a two-flop synchronizer and a stable-count deglitch filter, and finds START, repeated START and STOP conditions on the filtered pair. After every START it shifts in the first byte. If that byte carries the high-speed master-code prefix, the block raises `hs_mode`. This output shortens the deglitch window so the inputs can follow a 3.4 MHz clock. It also keeps the acknowledge hint low, because the master code is never acknowledged.

High-speed mode stays set across any number of repeated STARTs. Each transaction that follows uses ordinary byte framing, and its first byte is acknowledged as usual. Only a STOP returns the block to the longer F/S filter window. Address matching, register access and driving SDA are left to the logic downstream. That logic uses the filtered lines, the condition strobes and the `ack_enable` hint.

Top module: `hs_entry_watch`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `scl_f` and `sda_f` are 1, and `hs_mode`, `ack_enable`, `start_pulse`, `rstart_pulse` and `stop_pulse` are 0.
- R2: A fall of `sda_f` while `scl_f` is high gives a one-cycle strobe. The strobe is `start_pulse` when the bus is free (no START since the last STOP or reset), and `rstart_pulse` when a transaction is open. At most one of the three strobes is high in any cycle.
- R3: A rise of `sda_f` while `scl_f` is high gives a one-cycle `stop_pulse` and marks the bus free.
- R4: The first byte after any START or repeated START is sampled on rising `scl_f`, MSB first. If bits [7:3] equal 5'b00001, `hs_mode` is set, whatever bits [2:0] hold. Bytes such as 0x50 or 0x10 leave `hs_mode` unchanged.
- R5: Only the first byte after a START is examined. A master-code value in a later byte of the same transaction does not set `hs_mode`.
- R6: During the ninth clock of the first byte (from the `scl_f` fall after bit 0 to the next `scl_f` fall), `ack_enable` is 0 if the byte is a master code and 1 otherwise. It is 0 at all other times.
- R7: A repeated START while `hs_mode` is 1 leaves `hs_mode` at 1.
- R8: `hs_mode` is 0 in the cycle after `stop_pulse`, and the F/S filter window applies again.
- R9: A change on a raw line reaches its filtered output only after it has held for `FS_FILT_LEN` synchronized samples while `hs_mode` is 0, or for `HS_FILT_LEN` samples while it is 1. With the defaults (8 and 2), a 4-cycle SDA pulse is dropped in F/S mode and passed in HS mode. A 12-cycle pulse is passed in F/S mode.
- R10: A START or repeated START that arrives before eight bits have been collected discards the partial byte, and collection begins again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| scl_f | output | 1 | Filtered SCL |
| sda_f | output | 1 | Filtered SDA |
| start_pulse | output | 1 | One-cycle START strobe on a free bus |
| rstart_pulse | output | 1 | One-cycle repeated START strobe |
| stop_pulse | output | 1 | One-cycle STOP strobe |
| hs_mode | output | 1 | High-speed mode active; selects the short filter window |
| ack_enable | output | 1 | High while the first byte's acknowledge may be given |

## Verification
The assertions assume that SDA changes only while SCL is low, except when a START or STOP is intended. They also assume that each SCL level, and each SDA level around a condition, lasts longer than the active filter window, so that the filtered pair keeps the order of the raw edges. The bench drives the bus from tasks with a quarter period of 20 cycles in F/S mode and 6 cycles in HS mode. Both exceed the synchronizer plus filter delay for the window in use. The glitch scenarios break this timing on purpose only while SCL is held high, where a surviving pulse must appear as a repeated START followed by a STOP.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_COLLECT,
    PH_ACK_WAIT,
    PH_ACK_SLOT,
    PH_DONE
  } phase_t;

  localparam int BYTE_W = 8;
  localparam logic [4:0] MCODE_PREFIX = 5'b00001;

  function automatic logic is_master_code(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 5] == MCODE_PREFIX;
  endfunction
endpackage

// File: rtl/hsw_filter.sv
module hsw_filter #(
  parameter int LONG_LEN  = 8,
  parameter int SHORT_LEN = 2,
  localparam int CW = $clog2(LONG_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic short_sel,
  output logic filt
);
  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;

  assign thr = short_sel ? CW'(SHORT_LEN) : CW'(LONG_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      filt <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 != filt) begin
        if (cnt >= thr - CW'(1)) begin
          filt <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/hsw_cond_detect.sv
module hsw_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_pulse,
  output logic rstart_pulse,
  output logic stop_pulse
);
  logic p_scl, p_sda, busy;
  logic ev_start, ev_stop;

  assign ev_start = scl_f & p_scl & p_sda & ~sda_f;
  assign ev_stop  = scl_f & p_scl & ~p_sda & sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_scl        <= 1'b1;
      p_sda        <= 1'b1;
      busy         <= 1'b0;
      start_pulse  <= 1'b0;
      rstart_pulse <= 1'b0;
      stop_pulse   <= 1'b0;
    end else begin
      p_scl        <= scl_f;
      p_sda        <= sda_f;
      start_pulse  <= ev_start & ~busy;
      rstart_pulse <= ev_start & busy;
      stop_pulse   <= ev_stop;
      if (ev_start)     busy <= 1'b1;
      else if (ev_stop) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/hsw_byte_track.sv
module hsw_byte_track
  import hsw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  input  logic any_start,
  input  logic stop_seen,
  output logic hs_mode,
  output logic ack_enable
);
  localparam int BCW = $clog2(BYTE_W);

  phase_t            phase;
  logic [BCW-1:0]    bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_byte;
  logic              prev_scl, mcode;
  logic              scl_rise, scl_fall;

  assign scl_rise  = scl_f & ~prev_scl;
  assign scl_fall  = ~scl_f & prev_scl;
  assign next_byte = {shreg[BYTE_W-2:0], sda_f};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      prev_scl   <= 1'b1;
      mcode      <= 1'b0;
      hs_mode    <= 1'b0;
      ack_enable <= 1'b0;
    end else begin
      prev_scl <= scl_f;
      if (stop_seen) begin
        phase      <= PH_IDLE;
        bit_cnt    <= '0;
        hs_mode    <= 1'b0;
        ack_enable <= 1'b0;
      end else if (any_start) begin
        phase      <= PH_COLLECT;
        bit_cnt    <= '0;
        shreg      <= '0;
        mcode      <= 1'b0;
        ack_enable <= 1'b0;
      end else begin
        case (phase)
          PH_COLLECT: if (scl_rise) begin
            shreg <= next_byte;
            if (bit_cnt == BCW'(BYTE_W - 1)) begin
              phase <= PH_ACK_WAIT;
              mcode <= is_master_code(next_byte);
              if (is_master_code(next_byte)) hs_mode <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + BCW'(1);
            end
          end
          PH_ACK_WAIT: if (scl_fall) begin
            phase      <= PH_ACK_SLOT;
            ack_enable <= ~mcode;
          end
          PH_ACK_SLOT: if (scl_fall) begin
            phase      <= PH_DONE;
            ack_enable <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hs_entry_watch.sv
module hs_entry_watch #(
  parameter int FS_FILT_LEN = 8,
  parameter int HS_FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_f,
  output logic sda_f,
  output logic start_pulse,
  output logic rstart_pulse,
  output logic stop_pulse,
  output logic hs_mode,
  output logic ack_enable
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v, filt_v;

  assign raw_v = {sda_in, scl_in};
  assign scl_f = filt_v[0];
  assign sda_f = filt_v[1];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    hsw_filter #(
      .LONG_LEN (FS_FILT_LEN),
      .SHORT_LEN(HS_FILT_LEN)
    ) filt_i (
      .clk      (clk),
      .rst      (rst),
      .raw      (raw_v[i]),
      .short_sel(hs_mode),
      .filt     (filt_v[i])
    );
  end

  hsw_cond_detect cond_i (
    .clk         (clk),
    .rst         (rst),
    .scl_f       (scl_f),
    .sda_f       (sda_f),
    .start_pulse (start_pulse),
    .rstart_pulse(rstart_pulse),
    .stop_pulse  (stop_pulse)
  );

  hsw_byte_track track_i (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .any_start (start_pulse | rstart_pulse),
    .stop_seen (stop_pulse),
    .hs_mode   (hs_mode),
    .ack_enable(ack_enable)
  );
endmodule

// File: rtl/hsw_checker.sv
module hsw_checker (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic sda_f,
  input logic start_pulse,
  input logic rstart_pulse,
  input logic stop_pulse,
  input logic hs_mode,
  input logic ack_enable
);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_pulse, rstart_pulse, stop_pulse}));

  p_start_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (start_pulse || rstart_pulse) |-> ($past(scl_f) && !$past(sda_f)));

  p_stop_shape_r3: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> ($past(scl_f) && $past(sda_f)));

  p_mcode_no_ack_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> !ack_enable);

  p_hs_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (rstart_pulse && hs_mode) |=> hs_mode);

  p_hs_clear_r8: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !hs_mode);
endmodule

bind hs_entry_watch hsw_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .scl_f       (scl_f),
  .sda_f       (sda_f),
  .start_pulse (start_pulse),
  .rstart_pulse(rstart_pulse),
  .stop_pulse  (stop_pulse),
  .hs_mode     (hs_mode),
  .ack_enable  (ack_enable)
);

// File: tb/hs_entry_watch_tb_top.sv
`timescale 1ns/1ps
module hs_entry_watch_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_d = 1'b1, sda_d = 1'b1;
  logic scl_f, sda_f, start_pulse, rstart_pulse, stop_pulse, hs_mode, ack_enable;

  int total = 0, bad = 0;
  int n_start = 0, n_rstart = 0, n_stop = 0;
  int q = 20;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hs_entry_watch dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_d), .sda_in(sda_d),
    .scl_f(scl_f), .sda_f(sda_f), .start_pulse(start_pulse),
    .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
    .hs_mode(hs_mode), .ack_enable(ack_enable)
  );

  always @(negedge clk) if (!rst) begin
    if (start_pulse)  n_start++;
    if (rstart_pulse) n_rstart++;
    if (stop_pulse)   n_stop++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;   // from idle, both lines high
    sda_d = 1'b0; wt(q); scl_d = 1'b0; wt(q);
  endtask

  task automatic bus_rstart;  // from SCL low
    sda_d = 1'b1; wt(q); scl_d = 1'b1; wt(q); sda_d = 1'b0; wt(q); scl_d = 1'b0; wt(q);
  endtask

  task automatic bus_stop;    // from SCL low
    sda_d = 1'b0; wt(q); scl_d = 1'b1; wt(q); sda_d = 1'b1; wt(2 * q);
  endtask

  task automatic send_bit(input logic b);
    sda_d = b; wt(q); scl_d = 1'b1; wt(2 * q); scl_d = 1'b0; wt(q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_seen);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    sda_d = 1'b1; wt(q); scl_d = 1'b1; wt(q);
    ack_seen = ack_enable;
    wt(q); scl_d = 1'b0; wt(q);
  endtask

  task automatic t_reset;
    check("R1 scl_f", scl_f, 1);
    check("R1 sda_f", sda_f, 1);
    check("R1 hs_mode", hs_mode, 0);
    check("R1 ack_enable", ack_enable, 0);
    check("R1 strobes", start_pulse + rstart_pulse + stop_pulse, 0);
  endtask

  task automatic t_fs_plain;
    logic a;
    int s0 = n_start, r0 = n_rstart, p0 = n_stop;
    bus_start;
    check("R2 start strobe", n_start - s0, 1);
    send_byte(8'h50, a);
    check("R6 ack hint on ordinary byte", a, 1);
    check("R4 0x50 no hs", hs_mode, 0);
    check("R6 ack low after slot", ack_enable, 0);
    send_byte(8'h08, a);
    check("R5 second byte ignored hs", hs_mode, 0);
    check("R5 second byte no ack hint", a, 0);
    bus_stop;
    check("R3 stop strobe", n_stop - p0, 1);
    check("R2 no rstart", n_rstart - r0, 0);
  endtask

  task automatic t_near_miss;
    logic a;
    bus_start;
    send_byte(8'h10, a);
    check("R4 0x10 no hs", hs_mode, 0);
    check("R6 0x10 ack hint", a, 1);
    bus_stop;
  endtask

  task automatic t_partial;
    logic a;
    int r0 = n_rstart;
    bus_start;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_rstart;
    check("R2 rstart strobe", n_rstart - r0, 1);
    send_byte(8'h08, a);
    check("R10 restart count after partial", hs_mode, 1);
    check("R6 partial mcode no ack", a, 0);
    bus_stop;
    wt(2);
    check("R8 stop clears hs", hs_mode, 0);
  endtask

  task automatic t_hs_session;
    logic a;
    int r0, p0;
    bus_start;
    send_byte(8'h0D, a);
    check("R6 master code unacked", a, 0);
    check("R4 0x0D sets hs", hs_mode, 1);
    q = 6;
    r0 = n_rstart;
    bus_rstart;
    check("R7 rstart counted in hs", n_rstart - r0, 1);
    check("R7 hs held after rstart", hs_mode, 1);
    send_byte(8'h50, a);
    check("R6 hs address ack hint", a, 1);
    bus_rstart;
    send_byte(8'hA5, a);
    check("R7 hs held after second rstart", hs_mode, 1);
    // short SDA pulse while SCL high: passes with the short window
    r0 = n_rstart; p0 = n_stop;
    sda_d = 1'b1; wt(q); scl_d = 1'b1; wt(q);
    sda_d = 1'b0; wt(4); sda_d = 1'b1; wt(40);
    check("R9 hs glitch seen as rstart", n_rstart - r0, 1);
    check("R9 hs glitch seen as stop", n_stop - p0, 1);
    check("R8 hs cleared by stop", hs_mode, 0);
    q = 20;
  endtask

  task automatic t_fs_glitch;
    int s0 = n_start, p0 = n_stop;
    wt(20);
    sda_d = 1'b0; wt(4); sda_d = 1'b1; wt(40);
    check("R9 fs short pulse dropped", n_start - s0, 0);
    check("R9 fs short pulse sda_f", sda_f, 1);
    sda_d = 1'b0; wt(12); sda_d = 1'b1; wt(40);
    check("R9 fs long pulse start", n_start - s0, 1);
    check("R9 fs long pulse stop", n_stop - p0, 1);
  endtask

  initial begin
    wt(5);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    wt(10);
    t_fs_plain;
    t_near_miss;
    t_partial;
    t_hs_session;
    t_fs_glitch;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule